// File: doc/BRIEF.md
# Command Buffer Execution Sequencer

This block carries out one request on a shared, byte-wide, single-port data buffer. A one-cycle `start` pulse captures the command and response window descriptors: a byte address and a length for each. Each address is turned into an offset by subtracting the buffer's base address. Both windows are checked against the buffer length before anything moves.

An accepted request streams the command bytes out of the buffer to a backend over a valid/ready byte stream, then collects the backend's reply in a private scratch area. Once the reply ends, the sequencer zeroes every byte of the shared buffer and writes only the response window back. Stale command bytes therefore never remain readable. A rejected request touches nothing and finishes with an error flag.

Completion is a one-cycle `done` pulse, which the surrounding register file uses to drop its start bit. The buffer RAM port is driven by this block alone while it is busy. A read returns its data on the cycle after the access.

Top module: `cmdbuf_seq`

## Requirements
- R1: Out of reset `busy`, `done`, `error`, `cmd_valid`, `rsp_ready` and `buf_en` are all low.
- R2: A `start` pulse while idle raises `busy` on the next cycle. `busy` stays high up to and including the `done` cycle. A `start` while busy is ignored, and the descriptors captured at the accepted pulse are the ones used.
- R3: Offsets are computed as address minus `BASE_ADDR`, as unsigned values of AW bits that wrap around. A request is rejected when either offset exceeds `BUF_BYTES`, or when either offset plus its length exceeds `BUF_BYTES`. A rejected request sends no command byte, makes no buffer access and ends with `error` high.
- R4: An accepted request sends the bytes at buffer indices cmd_off .. cmd_off+cmd_size-1 in ascending order. `cmd_last` is high on the final byte. A zero `cmd_size` sends nothing.
- R5: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_data` and `cmd_last` hold.
- R6: After the command, `rsp_ready` is high until a beat with `rsp_last` is taken. The first `rsp_size` beats are kept and later beats are dropped.
- R7: After the last response beat, all `BUF_BYTES` buffer bytes are written with zero.
- R8: After that, exactly `rsp_size` bytes are written from index rsp_off upward. Byte k is the k-th kept response beat, or zero when the backend delivered fewer than k+1 beats.
- R9: `done` is high for exactly one cycle, and `busy` is low on the cycle after it. `error` is valid while `done` is high and holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request trigger pulse |
| cmd_addr | input | AW | Command window byte address |
| cmd_size | input | SW | Command length in bytes |
| rsp_addr | input | AW | Response window byte address |
| rsp_size | input | SW | Response length in bytes |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| error | output | 1 | Last request was rejected |
| buf_en | output | 1 | Buffer access enable |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | $clog2(BUF_BYTES) | Buffer byte index |
| buf_wdata | output | 8 | Buffer write byte |
| buf_rdata | input | 8 | Buffer read byte, one cycle after the access |
| cmd_valid | output | 1 | Command byte valid |
| cmd_data | output | 8 | Command byte |
| cmd_last | output | 1 | Final command byte |
| cmd_ready | input | 1 | Backend accepts command byte |
| rsp_valid | input | 1 | Response byte valid |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Final response byte |
| rsp_ready | output | 1 | Sequencer accepts response byte |

## Verification
The assertions take two things for granted. First, the buffer RAM answers a read on the next cycle. Second, the backend ends every reply with an `rsp_last` beat, because the sequencer waits for that beat without limit. The bench's RAM model has exactly that one-cycle read latency. Its backend model sends between one and seven reply beats and always marks the last one, and it starts only after the full command has arrived. The bench also throttles `cmd_ready` on a fixed pattern so that the holding rule is exercised. It fires a second `start` with different descriptors during every request.

// File: rtl/cmdbuf_seq.sv
module cmdbuf_seq #(
  parameter int BUF_BYTES = 256,
  parameter int AW = 32,
  parameter int SW = 32,
  parameter logic [AW-1:0] BASE_ADDR = 'h80
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [AW-1:0]                cmd_addr,
  input  logic [SW-1:0]                cmd_size,
  input  logic [AW-1:0]                rsp_addr,
  input  logic [SW-1:0]                rsp_size,
  output logic                         busy,
  output logic                         done,
  output logic                         error,
  output logic                         buf_en,
  output logic                         buf_we,
  output logic [$clog2(BUF_BYTES)-1:0] buf_addr,
  output logic [7:0]                   buf_wdata,
  input  logic [7:0]                   buf_rdata,
  output logic                         cmd_valid,
  output logic [7:0]                   cmd_data,
  output logic                         cmd_last,
  input  logic                         cmd_ready,
  input  logic                         rsp_valid,
  input  logic [7:0]                   rsp_data,
  input  logic                         rsp_last,
  output logic                         rsp_ready
);
  localparam int BW = $clog2(BUF_BYTES);
  localparam int CW = BW + 1;
  localparam int W  = ((AW > SW) ? AW : SW) + 1;
  localparam logic [W-1:0]  LIMIT    = W'(BUF_BYTES);
  localparam logic [CW-1:0] LAST_IDX = CW'(BUF_BYTES - 1);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_SEND, S_WAIT, S_CLEAR, S_WRITE, S_DONE} st_t;
  st_t st;

  logic [AW-1:0] c_off, r_off;
  logic [SW-1:0] c_sz, r_sz;
  logic [CW-1:0] cnt, rcnt;
  logic          pend, vld, err_q;
  logic [7:0]    cmd_q;
  logic [7:0]    scratch [BUF_BYTES];

  wire [W-1:0]  c_off_w = W'(c_off);
  wire [W-1:0]  r_off_w = W'(r_off);
  wire          bad = (c_off_w > LIMIT) || (c_off_w + W'(c_sz) > LIMIT) ||
                      (r_off_w > LIMIT) || (r_off_w + W'(r_sz) > LIMIT);
  wire [CW-1:0] c_len = c_sz[CW-1:0];
  wire [CW-1:0] r_len = r_sz[CW-1:0];
  wire          fetch = (st == S_SEND) && !pend && !vld && (cnt != c_len);
  wire          wr_rsp = (st == S_WRITE) && (cnt != r_len);
  wire          take = (st == S_WAIT) && rsp_valid;

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign error     = err_q;
  assign rsp_ready = (st == S_WAIT);
  assign cmd_valid = vld;
  assign cmd_data  = cmd_q;
  assign cmd_last  = vld && (cnt == c_len - CW'(1));
  assign buf_en    = fetch || (st == S_CLEAR) || wr_rsp;
  assign buf_we    = (st == S_CLEAR) || wr_rsp;
  assign buf_wdata = (wr_rsp && cnt < rcnt) ? scratch[cnt[BW-1:0]] : 8'h00;

  always_comb begin
    case (st)
      S_SEND:  buf_addr = c_off[BW-1:0] + cnt[BW-1:0];
      S_WRITE: buf_addr = r_off[BW-1:0] + cnt[BW-1:0];
      default: buf_addr = cnt[BW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (take && rcnt != r_len) scratch[rcnt[BW-1:0]] <= rsp_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      c_off <= '0;
      r_off <= '0;
      c_sz  <= '0;
      r_sz  <= '0;
      cnt   <= '0;
      rcnt  <= '0;
      pend  <= 1'b0;
      vld   <= 1'b0;
      err_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          c_off <= cmd_addr - BASE_ADDR;
          r_off <= rsp_addr - BASE_ADDR;
          c_sz  <= cmd_size;
          r_sz  <= rsp_size;
          err_q <= 1'b0;
          st    <= S_CHECK;
        end
        S_CHECK: begin
          cnt  <= '0;
          rcnt <= '0;
          pend <= 1'b0;
          vld  <= 1'b0;
          if (bad) begin
            err_q <= 1'b1;
            st    <= S_DONE;
          end else st <= S_SEND;
        end
        S_SEND: begin
          if (fetch) pend <= 1'b1;
          else if (!pend && !vld) st <= S_WAIT;
          if (pend) begin
            cmd_q <= buf_rdata;
            vld   <= 1'b1;
            pend  <= 1'b0;
          end
          if (vld && cmd_ready) begin
            vld <= 1'b0;
            cnt <= cnt + CW'(1);
          end
        end
        S_WAIT: if (take) begin
          if (rcnt != r_len) rcnt <= rcnt + CW'(1);
          if (rsp_last) begin
            cnt <= '0;
            st  <= S_CLEAR;
          end
        end
        S_CLEAR: begin
          cnt <= cnt + CW'(1);
          if (cnt == LAST_IDX) begin
            cnt <= '0;
            st  <= S_WRITE;
          end
        end
        S_WRITE: begin
          if (wr_rsp) cnt <= cnt + CW'(1);
          else st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R3
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !buf_en && !cmd_valid);
  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data) && $stable(cmd_last));
  // R6
  rsp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> busy && !cmd_valid && !buf_en);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
endmodule

// File: tb/cmdbuf_seq_bench.sv
module cmdbuf_seq_bench;
  localparam int N = 16;
  localparam logic [31:0] BASE = 32'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 1'b0;
  logic [31:0] cmd_addr = '0, cmd_size = '0, rsp_addr = '0, rsp_size = '0;
  logic        busy, done, error, buf_en, buf_we;
  logic [3:0]  buf_addr;
  logic [7:0]  buf_wdata, buf_rdata = '0;
  logic        cmd_valid, cmd_last, cmd_ready = 1'b0;
  logic [7:0]  cmd_data;
  logic        rsp_valid = 1'b0, rsp_last = 1'b0, rsp_ready;
  logic [7:0]  rsp_data = '0;

  cmdbuf_seq #(.BUF_BYTES(N), .BASE_ADDR(BASE)) u_cmdbuf_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_addr(cmd_addr), .cmd_size(cmd_size),
    .rsp_addr(rsp_addr), .rsp_size(rsp_size), .busy(busy), .done(done), .error(error),
    .buf_en(buf_en), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_last(cmd_last),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .rsp_ready(rsp_ready));

  logic [7:0] mem [N];
  always @(posedge clk) if (buf_en) begin
    if (buf_we) mem[buf_addr] <= buf_wdata;
    else buf_rdata <= mem[buf_addr];
  end

  logic [7:0] got_d [32];
  logic       got_l [32];
  int gcnt = 0;
  always @(posedge clk) if (cmd_valid && cmd_ready) begin
    got_d[gcnt % 32] <= cmd_data;
    got_l[gcnt % 32] <= cmd_last;
    gcnt <= gcnt + 1;
  end

  int cyc = 0;
  int checks = 0, fails = 0;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) cmd_ready <= (cyc % 3) != 1;

  always @(posedge clk) if (cyc > 150000) begin
    fails = fails + 1;
    $display("FAIL watchdog: act %0d cycles exp < 150000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] ca, input int cs, input logic [31:0] ra, input int rs,
                     input int nr, input int seed);
    logic [7:0] pre [N];
    logic [7:0] exp [N];
    longint co, ro;
    bit rej;
    int base, t, bad;
    for (int i = 0; i < N; i++) begin
      mem[i] = 8'((i * 37 + seed * 11 + 5) | 1);
      pre[i] = mem[i];
    end
    co = longint'(32'(ca - BASE));
    ro = longint'(32'(ra - BASE));
    rej = (co > N) || (co + cs > N) || (ro > N) || (ro + rs > N);
    @(negedge clk);
    cmd_addr = ca; cmd_size = cs; rsp_addr = ra; rsp_size = rs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    base = gcnt;
    cmd_addr = BASE; cmd_size = N; rsp_addr = BASE; rsp_size = N; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!rej) begin
      t = 0;
      while (gcnt - base < cs && t < 500) begin @(negedge clk); t++; end
      for (int k = 0; k < nr; k++) begin
        rsp_valid = 1'b1; rsp_data = 8'(k * 13 + seed + 1); rsp_last = (k == nr - 1);
        t = 0;
        @(posedge clk);
        while (!rsp_ready && t < 500) begin @(posedge clk); t++; end
        @(negedge clk);
      end
      rsp_valid = 1'b0; rsp_last = 1'b0;
    end
    t = 0;
    while (!done && t < 500) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R9", "done seen", int'(done), 1);
    chk(error == rej, "R3", "error flag", int'(error), int'(rej));
    @(negedge clk);
    chk(!done && !busy, "R9", "done/busy after pulse", int'({done, busy}), 0);
    for (int i = 0; i < N; i++) exp[i] = rej ? pre[i] : 8'h00;
    if (!rej) for (int k = 0; k < rs; k++)
      exp[int'(ro) + k] = (k < nr) ? 8'(k * 13 + seed + 1) : 8'h00;
    bad = 0;
    for (int i = 0; i < N; i++) if (mem[i] !== exp[i]) bad++;
    chk(bad == 0, rej ? "R3" : "R7/R8", "buffer bytes wrong", bad, 0);
    if (rej) chk(gcnt == base, "R3", "command bytes sent", gcnt - base, 0);
    else begin
      chk(gcnt - base == cs, "R4", "command byte count", gcnt - base, cs);
      bad = 0;
      for (int k = 0; k < cs; k++)
        if (got_d[(base + k) % 32] !== pre[int'(co) + k] || got_l[(base + k) % 32] !== (k == cs - 1)) bad++;
      chk(bad == 0, "R4", "command byte/last mismatches", bad, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error && !cmd_valid && !rsp_ready && !buf_en, "R1", "reset outputs",
        int'({busy, done, error, cmd_valid, rsp_ready, buf_en}), 0);
    rst_n = 1'b1;
    for (int co = 0; co <= N + 1; co++)
      for (int cs = 0; cs <= N + 1; cs++)
        run(BASE + 32'(co), cs, BASE + 32'd2, 5, 5, co * 19 + cs);
    for (int ro = 0; ro <= N + 1; ro++)
      for (int rs = 0; rs <= N + 1; rs++)
        run(BASE + 32'd1, 2, BASE + 32'(ro), rs, (ro + rs) % 7 + 1, ro * 7 + rs);
    run(BASE - 32'd1, 0, BASE, 1, 1, 3);
    run(BASE, 1, BASE - 32'd4, 0, 1, 4);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule